// File: doc/BRIEF.md
# Fused-Op Integer ALU

This block is a purely combinational integer execution unit for a 64-bit datapath. Besides plain add, subtract and bitwise logic, it executes the compound micro-operations that a decode stage forms when it merges two adjacent instructions. Examples are shift-then-add, mask-then-add, mask-then-or and add-then-extract. It also executes the conditional-zero pair and two byte-oriented bit-manipulation results. A 7-bit code selects the operation. A separate word-mode input moves the arithmetic operations onto a dedicated 32-bit adder, and the 32-bit result is then sign-extended to the full width.

The block has no state. The result follows operand A, operand B, the operation code and the word-mode flag within the same cycle. It sits between an issue stage and a writeback register.

Top module: `fused_alu`

## Requirements
- R1: Code 0x00 returns A+B, 0x01 returns A-B, 0x02 returns A&B, 0x03 returns A|B, 0x04 returns A^B. All five are 64-bit operations with wraparound.
- R2: When word_i=1 and the code is 0x00 (add), 0x01 (subtract) or 0x28 (odd-add), the result is the 32-bit sum or difference of the low halves, sign-extended from bit 31.
- R3: For every code other than 0x00, 0x01 and 0x28, word_i has no effect on the result.
- R4: Codes 0x10, 0x11 and 0x12 take the low 32 bits of A, zero-extend them, and shift the value left by 1, 2 and 3 respectively.
- R5: Code 0x14 returns A[15:8] in bits 7:0, with all other bits zero.
- R6: Code 0x20 returns (A<<4)+B. Codes 0x21, 0x22, 0x23 and 0x24 return (A>>K)+B, where the shift is logical and K is 29, 30, 31 and 32 respectively.
- R7: Code 0x28 returns (A&1)+B.
- R8: Code 0x29 returns A with bits 7:0 cleared, ORed with B.
- R9: Code 0x30 returns bits 7:0 of the 32-bit sum of the low halves, zero-extended. Code 0x31 returns bit 0 of that sum, zero-extended.
- R10: Codes 0x32, 0x33 and 0x34 return bit 0 of A&B, A|B and A^B respectively, zero-extended.
- R11: Code 0x40 returns 0 when B==0 and A otherwise. Code 0x41 returns 0 when B!=0 and A otherwise.
- R12: Code 0x48 reverses the byte order of A. Code 0x49 sets each byte of the result to 0xFF when the matching byte of A is nonzero, and to 0x00 otherwise.
- R13: Every code not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| op_i | input | 7 | Operation code |
| word_i | input | 1 | Selects the 32-bit path for add, subtract and odd-add |
| res_o | output | 64 | Result |

## Verification
The bench builds the block with its default width, DATA_W=64, which gives a 32-bit word path. At this width the right-shift amounts of 29 to 32 cross the boundary between the two halves. The operand set 0x8000_0000, all-ones and 0x7FFF_FFFF therefore exercises carries into bit 32, sign extension from bit 31, and the bit that moves across the half boundary for each shift-then-add code. Random codes over the full 7-bit space check that unassigned codes return zero and that word mode is ignored wherever it does not apply.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;
  localparam logic [6:0] OP_ADD      = 7'h00;
  localparam logic [6:0] OP_SUB      = 7'h01;
  localparam logic [6:0] OP_AND      = 7'h02;
  localparam logic [6:0] OP_OR       = 7'h03;
  localparam logic [6:0] OP_XOR      = 7'h04;
  localparam logic [6:0] OP_ZSL1     = 7'h10;
  localparam logic [6:0] OP_ZSL2     = 7'h11;
  localparam logic [6:0] OP_ZSL3     = 7'h12;
  localparam logic [6:0] OP_BYTE1    = 7'h14;
  localparam logic [6:0] OP_SL4ADD   = 7'h20;
  localparam logic [6:0] OP_SR29ADD  = 7'h21;
  localparam logic [6:0] OP_SR30ADD  = 7'h22;
  localparam logic [6:0] OP_SR31ADD  = 7'h23;
  localparam logic [6:0] OP_SR32ADD  = 7'h24;
  localparam logic [6:0] OP_LSBADD   = 7'h28;
  localparam logic [6:0] OP_MASKOR   = 7'h29;
  localparam logic [6:0] OP_WADDBYTE = 7'h30;
  localparam logic [6:0] OP_WADDBIT  = 7'h31;
  localparam logic [6:0] OP_ANDBIT   = 7'h32;
  localparam logic [6:0] OP_ORBIT    = 7'h33;
  localparam logic [6:0] OP_XORBIT   = 7'h34;
  localparam logic [6:0] OP_ZERO_EQ  = 7'h40;
  localparam logic [6:0] OP_ZERO_NE  = 7'h41;
  localparam logic [6:0] OP_BSWAP    = 7'h48;
  localparam logic [6:0] OP_BYTEOR   = 7'h49;

  function automatic logic op_known(input logic [6:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_ZSL1, OP_ZSL2, OP_ZSL3,
      OP_BYTE1, OP_SL4ADD, OP_SR29ADD, OP_SR30ADD, OP_SR31ADD, OP_SR32ADD,
      OP_LSBADD, OP_MASKOR, OP_WADDBYTE, OP_WADDBIT, OP_ANDBIT, OP_ORBIT,
      OP_XORBIT, OP_ZERO_EQ, OP_ZERO_NE, OP_BSWAP, OP_BYTEOR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_has_word(input logic [6:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_LSBADD);
  endfunction
endpackage

// File: rtl/fused_alu_lhs.sv
module fused_alu_lhs
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [6:0]        op_i,
  output logic [DATA_W-1:0] lhs_o
);
  // pre-adder operand shaping for the fused add forms
  always_comb begin
    case (op_i)
      OP_SL4ADD:  lhs_o = a_i << 4;
      OP_SR29ADD: lhs_o = a_i >> 29;
      OP_SR30ADD: lhs_o = a_i >> 30;
      OP_SR31ADD: lhs_o = a_i >> 31;
      OP_SR32ADD: lhs_o = a_i >> 32;
      OP_LSBADD:  lhs_o = DATA_W'(a_i[0]);
      default:    lhs_o = a_i;
    endcase
  end
endmodule

// File: rtl/fused_alu_add.sv
module fused_alu_add #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o,
  output logic [HALF_W-1:0] sum_w_o,
  output logic [HALF_W-1:0] diff_w_o
);
  // narrow adders kept apart from the wide ones to shorten the word path
  assign sum_o    = lhs_i + b_i;
  assign diff_o   = lhs_i - b_i;
  assign sum_w_o  = lhs_i[HALF_W-1:0] + b_i[HALF_W-1:0];
  assign diff_w_o = lhs_i[HALF_W-1:0] - b_i[HALF_W-1:0];
endmodule

// File: rtl/fused_alu_bits.sv
module fused_alu_bits #(
  parameter int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [1:0]        zsl_n_i,
  output logic [DATA_W-1:0] bswap_o,
  output logic [DATA_W-1:0] byteor_o,
  output logic [DATA_W-1:0] zsl_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign bswap_o[8*g +: 8]  = a_i[8*(NBYTES-1-g) +: 8];
    assign byteor_o[8*g +: 8] = {8{|a_i[8*g +: 8]}};
  end

  assign zsl_o = {{HALF_W{1'b0}}, a_i[HALF_W-1:0]} << zsl_n_i;

  always_comb begin
    if (zsl_n_i != 2'd0) begin
      AST_ZSL_TOP_CLEAR: assert (zsl_o[DATA_W-1:HALF_W+3] == '0) // R4
        else $error("zero-extend shift leaked into upper bits");
    end
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [6:0]        op_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] lhs, sum, diff, bswap, byteor, zsl;
  logic [HALF_W-1:0] sum_w, diff_w;
  logic [DATA_W-1:0] and_r, or_r, xor_r;
  logic              use_w;
  logic [1:0]        zsl_n;

  assign zsl_n = op_i[1:0] + 2'd1;

  fused_alu_lhs #(.DATA_W(DATA_W)) i_lhs (
    .a_i(a_i), .op_i(op_i), .lhs_o(lhs)
  );

  fused_alu_add #(.DATA_W(DATA_W)) i_add (
    .lhs_i(lhs), .b_i(b_i), .sum_o(sum), .diff_o(diff),
    .sum_w_o(sum_w), .diff_w_o(diff_w)
  );

  fused_alu_bits #(.DATA_W(DATA_W)) i_bits (
    .a_i(a_i), .zsl_n_i(zsl_n), .bswap_o(bswap), .byteor_o(byteor), .zsl_o(zsl)
  );

  assign and_r = a_i & b_i;
  assign or_r  = a_i | b_i;
  assign xor_r = a_i ^ b_i;
  assign use_w = word_i && op_has_word(op_i);

  always_comb begin
    res_o = '0;
    case (op_i)
      OP_ADD, OP_LSBADD:
        res_o = use_w ? {{HALF_W{sum_w[HALF_W-1]}}, sum_w} : sum;
      OP_SUB:
        res_o = use_w ? {{HALF_W{diff_w[HALF_W-1]}}, diff_w} : diff;
      OP_AND:      res_o = and_r;
      OP_OR:       res_o = or_r;
      OP_XOR:      res_o = xor_r;
      OP_ZSL1, OP_ZSL2, OP_ZSL3: res_o = zsl;
      OP_BYTE1:    res_o = DATA_W'(a_i[15:8]);
      OP_SL4ADD, OP_SR29ADD, OP_SR30ADD, OP_SR31ADD, OP_SR32ADD:
        res_o = sum;
      OP_MASKOR:   res_o = {a_i[DATA_W-1:8], 8'h00} | b_i;
      OP_WADDBYTE: res_o = DATA_W'(sum_w[7:0]);
      OP_WADDBIT:  res_o = DATA_W'(sum_w[0]);
      OP_ANDBIT:   res_o = DATA_W'(and_r[0]);
      OP_ORBIT:    res_o = DATA_W'(or_r[0]);
      OP_XORBIT:   res_o = DATA_W'(xor_r[0]);
      OP_ZERO_EQ:  res_o = (b_i == '0) ? '0 : a_i;
      OP_ZERO_NE:  res_o = (b_i != '0) ? '0 : a_i;
      OP_BSWAP:    res_o = bswap;
      OP_BYTEOR:   res_o = byteor;
      default:     res_o = '0;
    endcase
  end

  always_comb begin
    if (use_w) begin
      AST_WORD_SEXT: assert (res_o[DATA_W-1:HALF_W] == {HALF_W{res_o[HALF_W-1]}}) // R2
        else $error("word result not sign-extended");
    end
    if (op_i == OP_WADDBIT || op_i == OP_ANDBIT || op_i == OP_ORBIT || op_i == OP_XORBIT) begin
      AST_BIT_NARROW: assert (res_o[DATA_W-1:1] == '0) // R9
        else $error("single-bit result has upper bits set");
    end
    if (op_i == OP_ZERO_EQ && b_i == '0) begin
      AST_ZERO_EQ: assert (res_o == '0) // R11
        else $error("conditional zero on equal failed");
    end
    if (op_i == OP_ZERO_NE && b_i == '0) begin
      AST_ZERO_NE_PASS: assert (res_o == a_i) // R11
        else $error("conditional zero on nonequal did not pass A");
    end
    if (!op_known(op_i)) begin
      AST_UNKNOWN_ZERO: assert (res_o == '0) // R13
        else $error("unassigned code gave nonzero result");
    end
  end
endmodule

// File: tb/test_fused_alu.sv
module test_fused_alu;
  logic        clk = 1'b0;
  logic [63:0] a, b;
  logic [6:0]  op;
  logic        word;
  logic [63:0] res;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    logic [6:0]  op;
    logic        w;
    logic [63:0] a;
    logic [63:0] b;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk; // 50 MHz

  fused_alu i_fused_alu (.a_i(a), .b_i(b), .op_i(op), .word_i(word), .res_o(res));

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(input logic [6:0] o, input logic w,
                                        input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r;
    logic [31:0] s32;
    r = 64'd0;
    s32 = x[31:0] + y[31:0];
    case (o)
      7'h00: r = w ? sx32(x[31:0] + y[31:0]) : x + y;
      7'h01: r = w ? sx32(x[31:0] - y[31:0]) : x - y;
      7'h02: r = x & y;
      7'h03: r = x | y;
      7'h04: r = x ^ y;
      7'h10: r = {32'd0, x[31:0]} << 1;
      7'h11: r = {32'd0, x[31:0]} << 2;
      7'h12: r = {32'd0, x[31:0]} << 3;
      7'h14: r = {56'd0, x[15:8]};
      7'h20: r = (x << 4) + y;
      7'h21: r = (x >> 29) + y;
      7'h22: r = (x >> 30) + y;
      7'h23: r = (x >> 31) + y;
      7'h24: r = (x >> 32) + y;
      7'h28: r = w ? sx32({31'd0, x[0]} + y[31:0]) : {63'd0, x[0]} + y;
      7'h29: r = (x & ~64'hFF) | y;
      7'h30: r = {56'd0, s32[7:0]};
      7'h31: r = {63'd0, s32[0]};
      7'h32: r = {63'd0, x[0] & y[0]};
      7'h33: r = {63'd0, x[0] | y[0]};
      7'h34: r = {63'd0, x[0] ^ y[0]};
      7'h40: r = (y == 64'd0) ? 64'd0 : x;
      7'h41: r = (y != 64'd0) ? 64'd0 : x;
      7'h48: for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
      7'h49: for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] != 8'd0) ? 8'hFF : 8'h00;
      default: r = 64'd0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [6:0] o, input logic w);
    if (w && !(o == 7'h00 || o == 7'h01 || o == 7'h28) && o <= 7'h49) return "R3";
    case (o)
      7'h00, 7'h01: return w ? "R2" : "R1";
      7'h02, 7'h03, 7'h04: return "R1";
      7'h10, 7'h11, 7'h12: return "R4";
      7'h14: return "R5";
      7'h20, 7'h21, 7'h22, 7'h23, 7'h24: return "R6";
      7'h28: return w ? "R2" : "R7";
      7'h29: return "R8";
      7'h30, 7'h31: return "R9";
      7'h32, 7'h33, 7'h34: return "R10";
      7'h40, 7'h41: return "R11";
      7'h48, 7'h49: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic apply(input logic [6:0] o, input logic w,
                       input logic [63:0] x, input logic [63:0] y);
    item_t it;
    @(negedge clk);
    op = o; word = w; a = x; b = y;
    it.exp = model(o, w, x, y);
    it.op = o; it.w = w; it.a = x; it.b = y;
    sb_q.push_back(it);
  endtask

  // monitor: one result per rising edge, inputs settled since the falling edge
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (res !== it.exp) begin
        n_bad++;
        $display("FAIL %s op=%h w=%0d a=%h b=%h got=%h exp=%h",
                 tag(it.op, it.w), it.op, it.w, it.a, it.b, res, it.exp);
      end
    end
  end

  logic [6:0]  codes [25] = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h10, 7'h11, 7'h12,
                              7'h14, 7'h20, 7'h21, 7'h22, 7'h23, 7'h24, 7'h28, 7'h29,
                              7'h30, 7'h31, 7'h32, 7'h33, 7'h34, 7'h40, 7'h41, 7'h48,
                              7'h49};
  logic [63:0] edges [7] = '{64'd0, '1, 64'h8000_0000, 64'hFFFF_FFFF, 64'h7FFF_FFFF,
                             64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF};

  initial begin
    op = 7'h00; word = 1'b0; a = '0; b = '0;
    // zero operands on idle inputs: result must be zero (R1)
    apply(7'h00, 1'b0, 64'd0, 64'd0);
    // edge operands over every assigned code, both word settings (R1..R12, R3)
    foreach (codes[c])
      for (int w = 0; w < 2; w++)
        foreach (edges[i])
          foreach (edges[j])
            apply(codes[c], w[0], edges[i], edges[j]);
    // conditional-zero with B exactly zero (R11)
    apply(7'h40, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'd0);
    apply(7'h41, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'd0);
    // unassigned codes (R13)
    apply(7'h05, 1'b0, '1, '1);
    apply(7'h7F, 1'b1, '1, '1);
    // random codes across the full space, random operands
    for (int k = 0; k < 4000; k++)
      apply(7'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", n_vec, n_vec + sb_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule